// File: doc/BRIEF.md
# Four-Channel E1 Byte-Interleaved Serial Multiplexer

This block merges four 2.048 Mbit/s E1 payload channels into one 16.384 Mbit/s serial line. It sends every payload bit on two consecutive clocks. It interleaves the channels in groups of four payload bits. The order is: the first nibble of timeslot N for channels 0 to 3, then the second nibble of the same timeslot for channels 0 to 3, then timeslot N+1. A second output carries the ABCD signaling nibble of each channel. Each signaling bit is timed to line up with payload bits 5 to 8 of its own channel. A frame sync output marks the boundary between multiplexed frames and straddles it. A mode input sets the pulse width to four clocks or two clocks.

Data comes from an upstream store through a fetch handshake. Before each channel's first-nibble group, the block raises a one-clock request that names the channel and the timeslot. The store answers with a one-clock valid strobe that carries the octet and the signaling nibble. One multiplexed frame is 2048 clocks long: 32 timeslots × 4 channels × 8 bits × 2 clocks.

Top module: `e1_quad_mux`

## Requirements
- R1: A multiplexed frame lasts 2048 clocks. The frame position counter `p` wraps from 2047 to 0. The sync pulses repeat every 2048 clocks.
- R2: At frame position `p`, the fields are: slot = p[10:6], half = p[5], channel = p[4:3], pair = p[2:1]. `ser_out` carries bit (7 − (4·half + pair)) of that channel's current octet. Bit 7, the MSB, is payload bit 1.
- R3: Each payload bit stays on `ser_out` for two clocks: an even `p` and the odd `p` that follows it.
- R4: While half = 1, `sig_out` carries bit (3 − pair) of the channel's nibble, with bit 3 = A through bit 0 = D. Each signaling bit is held for two clocks. While half = 0, `sig_out` is low.
- R5: `fetch_req` is high for exactly one clock. This happens when p[2:0] = 0 in the group just before each first-half group. In that clock, `fetch_ch` and `fetch_slot` name the channel and the timeslot of the upcoming group.
- R6: A `fetch_vld` strobe at any clock up to and including the last clock of the requesting group supplies the data. That strobe may fall on the last clock itself. The octet and nibble it carries are used from the start of the requested group. They stay in use through that channel's second-half group in the same timeslot.
- R7: When `sync_wide` is 1, `sync_out` is high for p = 2046, 2047, 0 and 1.
- R8: When `sync_wide` is 0, `sync_out` is high for p = 2047 and 0.
- R9: Until the first counter wrap after reset, `sync_out` stays low. The first pulse begins at the end of the first full frame.
- R10: During reset, `ser_out`, `sig_out`, `sync_out` and `fetch_req` are low. Reset places the counter at p = 2039, so the first request comes on the first clock after reset. All held octets and nibbles are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 16.384 MHz line clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sync_wide | input | 1 | 1 selects the 4-clock sync pulse, 0 selects the 2-clock pulse |
| fetch_req | output | 1 | One-clock request for the next group's data |
| fetch_ch | output | 2 | Channel of the requested group |
| fetch_slot | output | 5 | Timeslot of the requested group |
| fetch_vld | input | 1 | Strobe that qualifies the fetched data |
| fetch_octet | input | 8 | Payload octet, MSB sent first |
| fetch_abcd | input | 4 | Signaling nibble, bit 3 = A |
| ser_out | output | 1 | Multiplexed serial data |
| sig_out | output | 1 | Signaling bit aligned with payload bits 5 to 8 |
| sync_out | output | 1 | Frame boundary pulse |

## Verification
The hardest case to reach is a valid strobe on the last clock of the requesting group. On that clock the data must go straight to the active register without passing through staging. Together with this, the second-half group must reuse an octet that was fetched four groups earlier. To reach both, the stimulus answers each request after a random delay of 1 to 7 clocks. It forces the extreme delays of 7 and 1 on the first requests. Every octet and nibble is fresh random data, so a stale or misrouted value is exposed. The sync pulse width is switched mid-frame, well away from any boundary. This covers both pulse shapes and the quiet period before the first wrap.

// File: rtl/e1_quad_mux.sv
module e1_quad_mux (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sync_wide,
  output logic       fetch_req,
  output logic [1:0] fetch_ch,
  output logic [4:0] fetch_slot,
  input  logic       fetch_vld,
  input  logic [7:0] fetch_octet,
  input  logic [3:0] fetch_abcd,
  output logic       ser_out,
  output logic       sig_out,
  output logic       sync_out
);
  localparam int PW         = 11;
  localparam int FRAME_LAST = (1 << PW) - 1;
  localparam logic [PW-1:0] RST_POS = PW'(FRAME_LAST - 8);

  logic [PW-1:0] pos;
  logic [7:0]    oct_q [4];
  logic [3:0]    abcd_q [4];
  logic [7:0]    stg_oct;
  logic [3:0]    stg_abcd;
  logic          armed, tail_seen;

  wire [7:0] grp_nxt   = pos[PW-1:3] + 8'd1;
  wire       nxt_head  = ~grp_nxt[2];
  wire       grp_end   = (pos[2:0] == 3'd7);
  wire       half      = pos[5];
  wire [1:0] ch        = pos[4:3];
  wire [1:0] pair      = pos[2:1];
  wire [2:0] bsel      = 3'd7 - {half, pair};

  wire tail_win = sync_wide ? (pos >= PW'(FRAME_LAST - 1)) : (pos == PW'(FRAME_LAST));
  wire head_win = sync_wide ? (pos <= PW'(1)) : (pos == '0);
  wire tail_on  = armed & tail_win;

  assign fetch_req  = (pos[2:0] == 3'd0) & nxt_head;
  assign fetch_ch   = grp_nxt[1:0];
  assign fetch_slot = grp_nxt[7:3];
  assign ser_out    = oct_q[ch][bsel];
  assign sig_out    = half & abcd_q[ch][2'd3 - pair];
  assign sync_out   = tail_on | (tail_seen & head_win);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos       <= RST_POS;
      armed     <= 1'b0;
      tail_seen <= 1'b0;
      stg_oct   <= '0;
      stg_abcd  <= '0;
      for (int i = 0; i < 4; i++) begin
        oct_q[i]  <= '0;
        abcd_q[i] <= '0;
      end
    end else begin
      pos <= pos + PW'(1);
      if (pos == PW'(FRAME_LAST)) begin
        armed     <= 1'b1;
        tail_seen <= tail_on;
      end
      if (fetch_vld) begin
        stg_oct  <= fetch_octet;
        stg_abcd <= fetch_abcd;
      end
      if (grp_end && nxt_head) begin
        oct_q[grp_nxt[1:0]]  <= fetch_vld ? fetch_octet : stg_oct;
        abcd_q[grp_nxt[1:0]] <= fetch_vld ? fetch_abcd  : stg_abcd;
      end
    end
  end
endmodule

module e1_quad_mux_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [10:0] pos,
  input logic        fetch_req,
  input logic        ser_out,
  input logic        sig_out,
  input logic        sync_out
);
  assert_req_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_req |=> !fetch_req);
  assert_bit_repeat_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (pos[0] && pos != 11'd2039) |-> ser_out == $past(ser_out));
  assert_sig_repeat_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (pos[0] && pos != 11'd2039) |-> sig_out == $past(sig_out));
  assert_sync_rise_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sync_out) |-> (pos == 11'd2046 || pos == 11'd2047));
  assert_sync_fall_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sync_out) |-> (pos == 11'd1 || pos == 11'd2));
endmodule

bind e1_quad_mux e1_quad_mux_chk chk_i (
  .clk(clk), .rst_n(rst_n), .pos(pos), .fetch_req(fetch_req),
  .ser_out(ser_out), .sig_out(sig_out), .sync_out(sync_out));

// File: tb/e1_quad_mux_tb.sv
module e1_quad_mux_tb_top;
  logic clk = 1'b0, rst_n = 1'b0, sync_wide = 1'b1;
  logic fetch_vld = 1'b0;
  logic [7:0] fetch_octet = '0;
  logic [3:0] fetch_abcd = '0;
  logic fetch_req, ser_out, sig_out, sync_out;
  logic [1:0] fetch_ch;
  logic [4:0] fetch_slot;

  int n_chk = 0, n_bad = 0;
  logic [10:0] m_pos;
  int wraps = 0;
  logic [7:0] exp_oct [4];
  logic [3:0] exp_abcd [4];
  logic [7:0] pend_oct;
  logic [3:0] pend_abcd;
  int lat = 0, nreq = 0;

  always #4 clk = ~clk;

  e1_quad_mux dut_i (
    .clk(clk), .rst_n(rst_n), .sync_wide(sync_wide),
    .fetch_req(fetch_req), .fetch_ch(fetch_ch), .fetch_slot(fetch_slot),
    .fetch_vld(fetch_vld), .fetch_octet(fetch_octet), .fetch_abcd(fetch_abcd),
    .ser_out(ser_out), .sig_out(sig_out), .sync_out(sync_out));

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s pos=%0d actual=%0h expected=%0h", tag, m_pos, act, exp);
    end
  endtask

  function automatic logic exp_ser(input logic [10:0] p);
    logic [2:0] b = 3'd7 - {p[5], p[2:1]};
    return exp_oct[p[4:3]][b];
  endfunction

  function automatic logic exp_sig(input logic [10:0] p);
    return p[5] ? exp_abcd[p[4:3]][2'd3 - p[2:1]] : 1'b0;
  endfunction

  function automatic logic exp_sync(input logic [10:0] p, input logic w, input int nw);
    logic tw = w ? (p >= 11'd2046) : (p == 11'd2047);
    logic hw = w ? (p <= 11'd1) : (p == 11'd0);
    return (nw >= 1 && tw) || (nw >= 2 && hw);
  endfunction

  initial begin
    #(200000 * 8);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [7:0] ng;
    string t;
    void'($urandom(32'd20240611));
    for (int i = 0; i < 4; i++) begin exp_oct[i] = '0; exp_abcd[i] = '0; end
    m_pos = 11'd2039;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R10 ser", {7'd0, ser_out}, 8'd0);
    chk("R10 sig", {7'd0, sig_out}, 8'd0);
    chk("R10 sync", {7'd0, sync_out}, 8'd0);
    chk("R10 req", {7'd0, fetch_req}, 8'd0);
    rst_n = 1'b1;
    for (int cyc = 0; cyc < 6 * 2048 + 64; cyc++) begin
      @(posedge clk);
      ng = m_pos[10:3] + 8'd1;
      if (m_pos[2:0] == 3'd7 && !ng[2]) begin
        exp_oct[ng[1:0]]  = pend_oct;
        exp_abcd[ng[1:0]] = pend_abcd;
      end
      m_pos = m_pos + 11'd1;
      if (m_pos == 11'd0) wraps++;
      @(negedge clk);
      if (wraps == 3 && m_pos == 11'd1000) sync_wide = 1'b0;
      fetch_vld = 1'b0;
      if (lat > 0) begin
        lat--;
        if (lat == 0) begin
          fetch_vld = 1'b1; fetch_octet = pend_oct; fetch_abcd = pend_abcd;
        end
      end
      t = m_pos[0] ? "R3 ser" : (m_pos[5] ? "R6 ser" : "R2 ser");
      chk(t, {7'd0, ser_out}, {7'd0, exp_ser(m_pos)});
      chk("R4 sig", {7'd0, sig_out}, {7'd0, exp_sig(m_pos)});
      if (wraps < 2 && m_pos < 11'd2000) t = "R9 sync";
      else if (m_pos == 11'd0) t = "R1 sync";
      else t = sync_wide ? "R7 sync" : "R8 sync";
      chk(t, {7'd0, sync_out}, {7'd0, exp_sync(m_pos, sync_wide, wraps)});
      ng = m_pos[10:3] + 8'd1;
      chk("R5 req", {7'd0, fetch_req}, {7'd0, (m_pos[2:0] == 3'd0) && !ng[2]});
      if (m_pos[2:0] == 3'd0 && !ng[2]) begin
        chk("R5 ch", {6'd0, fetch_ch}, {6'd0, ng[1:0]});
        chk("R5 slot", {3'd0, fetch_slot}, {3'd0, ng[7:3]});
        pend_oct  = 8'($urandom);
        pend_abcd = 4'($urandom);
        if (nreq < 3) lat = 7;
        else if (nreq < 6) lat = 1;
        else lat = $urandom_range(1, 7);
        nreq++;
      end
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule